// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Registers

This block collects the per-channel event pulses of a multi-channel DMA engine and turns them into software-visible state. Each channel sequencer reports a finished command, a termination error or a bus error as single-cycle pulses. The block records them as pending flags and drives one interrupt line per channel. It also holds the per-channel freeze bits that pause a sequencer and the reset requests that restart one.

Software reaches four 32-bit registers through a word-addressed read/write port. Every register has three write views. A plain write replaces the value. A set view ORs in the ones of the write data. A clear view removes the ones of the write data. Handlers can therefore acknowledge or enable single channels without a read-modify-write. The host port carries the word address, which is the byte address shifted right by two. Bits 3:2 of the word address select the register: 0 is control, 1 is completion, 2 is error and 3 is channel control. Bits 1:0 select the view: 0 is the plain write (byte offset +0x0), 1 is set (+0x4), 2 is clear (+0x8) and 3 is an inert view (+0xC).

Top module: `dma_irq_regs`

## Requirements
- R1: After reset every register reads zero, every interrupt line is low, both burst enables are off, and no channel is frozen or being reset.
- R2: Reads are combinational and return the register chosen by word-address bits 3:2 under any of its four views. Only bit 0 (burst enable) and bit 1 (eight-beat burst enable) of the control register are stored; its other bits always read zero.
- R3: A write at view 0 replaces the register with the write data. View 1 sets the ones of the write data and view 2 clears them, with all other bits unchanged. A write at view 3 changes nothing.
- R4: A completion pulse on channel i sets completion-register bit i, which is the pending flag. Bits 31:16 of that register are the per-channel interrupt enables and are written only by software.
- R5: An error event on channel i sets error-register bit i and loads error-register bit 16+i with the cause: 1 for a bus error and 0 for a termination error. A bus error in the same cycle as a termination error records cause 1.
- R6: A termination error in the same cycle as a completion on the same channel, with no bus error, counts only as a completion. The error pending flag of that channel is not set.
- R7: Interrupt line i is high exactly when completion bit i and its enable bit 16+i are both set, or when error bit i is set. It follows the register state with no further delay.
- R8: Channel-control bits 15:0 drive the channel freeze outputs directly. Clearing a bit releases that channel.
- R9: Writing a 1 to channel-control bit 16+i raises the reset output of channel i for exactly one cycle. The bit then reads zero again unless it is written once more.
- R10: When a hardware event and a software clear of the same pending bit fall in the same cycle, the event wins. The bit stays set and the error cause takes the event's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the host port |
| host_waddr | input | 4 | Word address: bits 3:2 pick the register, bits 1:0 the view |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the addressed register |
| ev_cmp | input | 16 | Per-channel completion pulses |
| ev_term | input | 16 | Per-channel termination-error pulses |
| ev_bus | input | 16 | Per-channel bus-error pulses |
| irq | output | 16 | Per-channel interrupt lines |
| chan_freeze | output | 16 | Per-channel pause requests |
| chan_reset | output | 16 | Per-channel one-cycle reset pulses |
| burst_en | output | 1 | Burst transfers enabled |
| burst8_en | output | 1 | Eight-beat bursts enabled |

## Verification
The bound checker watches, on every cycle, that an event pulse shows up in the pending flags on the next edge. It also watches that a bus error records cause 1 and that a completion suppresses a termination error on the same channel. It checks that every pending error drives its interrupt line, that no line is high without a reason, and that an unrenewed reset request drops after one cycle. The meaning of each write view, the masking of the control register, the inert fourth view and the contest between a software clear and a hardware event in the same cycle are shown only by the bench's directed and random scenarios. In those scenarios every register is read back and compared with a model after each step.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int REG_COUNT = 4;
    localparam int CTRL_W    = 2;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_DONE  = 2'd1,
        REG_FAULT = 2'd2,
        REG_CHAN  = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    typedef struct packed {
        logic     wr;
        reg_idx_e idx;
        wr_op_e   op;
    } host_req_t;

endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
    import dirq_pkg::*;
(
    input  logic                 host_wr,
    input  logic [3:0]           host_waddr,
    output host_req_t            req,
    output logic [REG_COUNT-1:0] hit
);

    always_comb begin
        req.wr  = host_wr;
        req.idx = reg_idx_e'(host_waddr[3:2]);
        req.op  = wr_op_e'(host_waddr[1:0]);
    end

    for (genvar k = 0; k < REG_COUNT; k++) begin : g_hit
        assign hit[k] = req.wr && (req.op != OP_NONE) && (req.idx == reg_idx_e'(k));
    end

endmodule

// File: rtl/dirq_alias_apply.sv
module dirq_alias_apply
    import dirq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    input  wr_op_e       op,
    output logic [W-1:0] nxt
);

    always_comb begin
        nxt = cur;
        if (hit) begin
            unique case (op)
                OP_WRITE: nxt = wdata;
                OP_SET:   nxt = cur | wdata;
                OP_CLR:   nxt = cur & ~wdata;
                default:  nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/dirq_event_merge.sv
module dirq_event_merge #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] ev_cmp,
    input  logic [NCH-1:0] ev_term,
    input  logic [NCH-1:0] ev_bus,
    output logic [NCH-1:0] done_set,
    output logic [NCH-1:0] fault_set,
    output logic [NCH-1:0] fault_bus
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // A termination that coincides with a completion is a normal end.
        logic term_only;
        assign term_only    = ev_term[i] && !ev_cmp[i];
        assign done_set[i]  = ev_cmp[i];
        assign fault_set[i] = ev_bus[i] || term_only;
        assign fault_bus[i] = ev_bus[i];
    end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dirq_pkg::*;
#(
    parameter int NCH = 16,
    localparam int DW = 2 * NCH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [3:0]    host_waddr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [NCH-1:0] ev_cmp,
    input  logic [NCH-1:0] ev_term,
    input  logic [NCH-1:0] ev_bus,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] chan_freeze,
    output logic [NCH-1:0] chan_reset,
    output logic          burst_en,
    output logic          burst8_en
);

    localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CTRL_W) - 1);

    host_req_t            req;
    logic [REG_COUNT-1:0] hit;
    logic [DW-1:0]        reg_q  [REG_COUNT];
    logic [DW-1:0]        sw_nxt [REG_COUNT];
    logic [NCH-1:0]       done_set, fault_set, fault_bus;

    dirq_decode u_decode (
        .host_wr    (host_wr),
        .host_waddr (host_waddr),
        .req        (req),
        .hit        (hit)
    );

    for (genvar k = 0; k < REG_COUNT; k++) begin : g_alias
        dirq_alias_apply #(.W(DW)) u_apply (
            .cur   (reg_q[k]),
            .wdata (host_wdata),
            .hit   (hit[k]),
            .op    (req.op),
            .nxt   (sw_nxt[k])
        );
    end

    dirq_event_merge #(.NCH(NCH)) u_merge (
        .ev_cmp    (ev_cmp),
        .ev_term   (ev_term),
        .ev_bus    (ev_bus),
        .done_set  (done_set),
        .fault_set (fault_set),
        .fault_bus (fault_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < REG_COUNT; k++) reg_q[k] <= '0;
        end else begin
            reg_q[REG_CTRL]  <= sw_nxt[REG_CTRL] & CTRL_MASK;
            // Hardware events override a same-cycle software clear.
            reg_q[REG_DONE]  <= {sw_nxt[REG_DONE][DW-1:NCH],
                                 sw_nxt[REG_DONE][NCH-1:0] | done_set};
            reg_q[REG_FAULT] <= {(sw_nxt[REG_FAULT][DW-1:NCH] & ~fault_set) |
                                 (fault_bus & fault_set),
                                 sw_nxt[REG_FAULT][NCH-1:0] | fault_set};
            // Reset requests live for one cycle unless rewritten.
            reg_q[REG_CHAN]  <= {hit[REG_CHAN] ? sw_nxt[REG_CHAN][DW-1:NCH] : '0,
                                 sw_nxt[REG_CHAN][NCH-1:0]};
        end
    end

    assign host_rdata  = reg_q[req.idx];
    assign irq         = (reg_q[REG_DONE][NCH-1:0] & reg_q[REG_DONE][DW-1:NCH]) |
                         reg_q[REG_FAULT][NCH-1:0];
    assign chan_freeze = reg_q[REG_CHAN][NCH-1:0];
    assign chan_reset  = reg_q[REG_CHAN][DW-1:NCH];
    assign burst_en    = reg_q[REG_CTRL][0];
    assign burst8_en   = reg_q[REG_CTRL][1];

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker #(
    parameter int NCH = 16,
    localparam int DW = 2 * NCH
) (
    input logic           clk,
    input logic           rst,
    input logic           host_wr,
    input logic [NCH-1:0] ev_cmp,
    input logic [NCH-1:0] ev_term,
    input logic [NCH-1:0] ev_bus,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] chan_reset,
    input logic [DW-1:0]  done_q,
    input logic [DW-1:0]  fault_q
);

    logic [NCH-1:0] term_with_cmp;
    assign term_with_cmp = ev_term & ev_cmp & ~ev_bus;

    p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
        (|ev_cmp) |=> ((done_q[NCH-1:0] & $past(ev_cmp)) == $past(ev_cmp)));

    p_bus_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (|ev_bus) |=> ((fault_q[DW-1:NCH] & fault_q[NCH-1:0] & $past(ev_bus)) == $past(ev_bus)));

    p_term_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (|term_with_cmp) |=>
        ((fault_q[NCH-1:0] & ~$past(fault_q[NCH-1:0]) & $past(term_with_cmp)) == '0));

    p_irq_fault_r7: assert property (@(posedge clk) disable iff (rst)
        ((irq & fault_q[NCH-1:0]) == fault_q[NCH-1:0]));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (((done_q[NCH-1:0] & done_q[DW-1:NCH]) | fault_q[NCH-1:0]) == '0) |-> (irq == '0));

    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ((|chan_reset) && !host_wr) |=> (chan_reset == '0));

endmodule

bind dma_irq_regs dirq_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .ev_cmp     (ev_cmp),
    .ev_term    (ev_term),
    .ev_bus     (ev_bus),
    .irq        (irq),
    .chan_reset (chan_reset),
    .done_q     (reg_q[1]),
    .fault_q    (reg_q[2])
);

// File: tb/dma_irq_regs_test.sv
`timescale 1ns/1ps
module dma_irq_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [3:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] ev_cmp = '0, ev_term = '0, ev_bus = '0;
    logic [15:0] irq, chan_freeze, chan_reset;
    logic        burst_en, burst8_en;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_reg [4];

    always #4 clk = ~clk;

    dma_irq_regs uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_cmp(ev_cmp), .ev_term(ev_term), .ev_bus(ev_bus),
        .irq(irq), .chan_freeze(chan_freeze), .chan_reset(chan_reset),
        .burst_en(burst_en), .burst8_en(burst8_en)
    );

    function automatic logic [31:0] view_apply(logic [31:0] cur, logic [31:0] wd, logic [1:0] op);
        case (op)
            2'd0:    return wd;
            2'd1:    return cur | wd;
            2'd2:    return cur & ~wd;
            default: return cur;
        endcase
    endfunction

    task automatic model_step(logic wr, logic [3:0] wa, logic [31:0] wd,
                              logic [15:0] c, logic [15:0] t, logic [15:0] b);
        logic [31:0] sw [4];
        logic [15:0] eset;
        logic        chan_hit;
        for (int k = 0; k < 4; k++)
            sw[k] = (wr && wa[3:2] == k[1:0]) ? view_apply(m_reg[k], wd, wa[1:0]) : m_reg[k];
        chan_hit = wr && wa[3:2] == 2'd3 && wa[1:0] != 2'd3;
        eset = b | (t & ~c);
        m_reg[0] = sw[0] & 32'h3;
        m_reg[1] = {sw[1][31:16], sw[1][15:0] | c};
        m_reg[2] = {(sw[2][31:16] & ~eset) | (b & eset), sw[2][15:0] | eset};
        m_reg[3] = {chan_hit ? sw[3][31:16] : 16'h0, sw[3][15:0]};
    endtask

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [15:0] exp_irq;
        exp_irq = (m_reg[1][15:0] & m_reg[1][31:16]) | m_reg[2][15:0];
        cmp(tag, "irq", {16'h0, irq}, {16'h0, exp_irq});
        cmp(tag, "freeze", {16'h0, chan_freeze}, {16'h0, m_reg[3][15:0]});
        cmp(tag, "reset", {16'h0, chan_reset}, {16'h0, m_reg[3][31:16]});
        cmp(tag, "burst", {30'h0, burst8_en, burst_en}, {30'h0, m_reg[0][1:0]});
        for (int k = 0; k < 4; k++) begin
            host_waddr = {k[1:0], k[1:0]};   // R2: any view reads the register
            #0.5;
            cmp(tag, "rdata", host_rdata, m_reg[k]);
        end
    endtask

    task automatic step(string tag, logic wr, logic [3:0] wa, logic [31:0] wd,
                        logic [15:0] c, logic [15:0] t, logic [15:0] b);
        @(negedge clk);
        host_wr = wr; host_waddr = wa; host_wdata = wd;
        ev_cmp = c; ev_term = t; ev_bus = b;
        model_step(wr, wa, wd, c, t, b);
        @(posedge clk);
        #0.5;
        host_wr = 1'b0; ev_cmp = '0; ev_term = '0; ev_bus = '0;
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) m_reg[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check_all("R1");

        // R2: only two control bits stored
        step("R2", 1, 4'h0, 32'hFFFF_FFFF, 0, 0, 0);
        // R3: clear view at +0x8
        step("R3", 1, 4'h2, 32'h0000_0001, 0, 0, 0);
        // R3: set view enables channels 0 and 2
        step("R3", 1, 4'h5, 32'h0005_0000, 0, 0, 0);
        // R4 / R7: completion on an enabled channel raises its line
        step("R4", 0, 0, 0, 16'h0001, 0, 0);
        // R7: completion on a disabled channel stays quiet
        step("R7", 0, 0, 0, 16'h0002, 0, 0);
        // R6: termination coinciding with completion
        step("R6", 0, 0, 0, 16'h0004, 16'h0004, 0);
        // R5: termination alone, cause 0
        step("R5", 0, 0, 0, 0, 16'h0008, 0);
        // R5: bus with termination, cause 1
        step("R5", 0, 0, 0, 0, 16'h0010, 16'h0010);
        // R10: software clears all error flags while channel 0 sees a bus error
        step("R10", 1, 4'hA, 32'hFFFF_FFFF, 0, 0, 16'h0001);
        // R10: completion beats clear of completion flags
        step("R10", 1, 4'h6, 32'h0000_FFFF, 16'h0002, 0, 0);
        // R3: inert view at +0xC
        step("R3", 1, 4'h7, 32'hFFFF_FFFF, 0, 0, 0);
        step("R3", 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
        // R8: freeze then release
        step("R8", 1, 4'hD, 32'h0000_0003, 0, 0, 0);
        step("R8", 1, 4'hE, 32'h0000_0001, 0, 0, 0);
        // R9: reset pulse lasts one cycle
        step("R9", 1, 4'hC, 32'h0005_0002, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0);
        // R3: plain write replaces the error register
        step("R3", 1, 4'h8, 32'h1234_0000, 0, 0, 0);

        void'($urandom(32'd2718));
        for (int n = 0; n < 500; n++) begin
            logic        wr;
            logic [3:0]  wa;
            logic [31:0] wd;
            logic [15:0] c, t, b;
            wr = ($urandom % 3) == 0;
            wa = 4'($urandom);
            wd = $urandom;
            c  = 16'($urandom & $urandom & $urandom);
            t  = 16'($urandom & $urandom & $urandom);
            b  = 16'($urandom & $urandom & $urandom & $urandom);
            step("R3/R4/R5/R6/R7/R9/R10 random", wr, wa, wd, c, t, b);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule